// File: doc/BRIEF.md
# Timestamp Threshold Interrupt Quad

This block captures transmit timestamps for a quad of four PHY ports and tells software when they are waiting. Each port owns a small timestamp memory. A capture strobe on a port stores the current value of a local time counter into the lowest free slot. A slot read through the register bus returns the stored value and frees that slot. Each port keeps a bitmap of occupied slots, a count of outstanding timestamps, a sticky overflow flag and a configuration word that holds an interrupt threshold and an enable bit.

Each port keeps a level-type interrupt cause. The cause is raised while the port is enabled and its outstanding count is at or above the threshold. It drops only when a read takes the count below the threshold that was in force when the cause rose. The four causes are ORed into a single quad interrupt. A cause that rose with a zero threshold can therefore never drop, and it masks every other port of the quad. The only way out is the local soft reset bit in the global register. A reset arriving from the MAC side has no effect on the timestamp state. That input clears only the bus read-data register on the MAC side.

Software uses the block in three steps. It writes the threshold first and sets the enable bit in a later write. It then services the quad interrupt by reading the status word and the slots. During initialisation it pulses the soft reset bit (clear, set, clear) to clear any stale state.

Top module: `tsq_irq_unit`

## Requirements
- R1: After power-on reset (`por_rst_n` low) every configuration word, status word, slot, the global register, `bus_rdata` and `quad_irq` read as zero. Address map: global 0x00; port p (0..3) block at 0x10*(p+1), with config at +0x0 (threshold bits [2:0], enable bit 4), status at +0x4 and slot s at +0x8+s.
- R2: A capture strobe on a port with a free slot stores the time counter into the lowest-numbered free slot, sets its valid bit and increments the count. The status word shows the valid bitmap in bits [3:0], overflow in bit 8, the count in bits [18:16] and the cause in bit 24.
- R3: A capture into a port whose four slots are all valid is dropped and sets the overflow bit. That bit stays set until soft reset or power-on reset.
- R4: `bus_rdata` updates on the clock edge after a cycle with `bus_rd` high and otherwise holds its value. Reading a valid slot returns its timestamp, clears its valid bit and decrements the count. Reading an empty slot returns 0 and changes nothing.
- R5: When a port is enabled and its count is greater than or equal to its threshold, its cause is high on the next clock edge. With threshold 1, a single capture raises it.
- R6: A raised cause drops only on a read that lowers the count below the threshold captured when the cause rose. Rewriting the threshold or clearing the enable bit never drops it, so a cause raised with threshold 0 stays high.
- R7: `quad_irq` is high exactly when at least one port cause is high, so a port whose cause stays high hides the causes of the other ports.
- R8: Writing bit 11 of the global register sets the soft reset bit. In every cycle in which that bit is set, the next edge clears all slots, valid bits, counts, overflow flags, causes and the time counter. Configuration words are kept.
- R9: Holding `mac_rst_n` low forces `bus_rdata` to zero and leaves every timestamp, status, configuration and interrupt state unchanged.
- R10: The 16-bit time counter starts at 0 on the edge that ends a soft reset and increments on every following edge. A capture stores the counter value of the cycle in which the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, synchronous |
| mac_rst_n | input | 1 | MAC-side reset, active low; clears read data only |
| cap_strobe | input | 4 | Per-port timestamp capture strobe |
| bus_wr | input | 1 | Register write enable |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| quad_irq | output | 1 | OR of the four port interrupt causes |

## Verification
The bench targets the threshold-of-one raise and clear. A design that compared with strict greater-than, or cleared at equality, would leave the interrupt off or drop it one read early. It enables a port with threshold 0 in a single write, then rewrites the threshold, captures and drains the port. A design that re-evaluated the clear against the new threshold would wrongly release the stuck cause and unmask the quad. It checks that a held MAC reset keeps every status word, and that the clear-set-clear soft reset pulse empties all ports, keeps the configuration and restarts the time counter from 0. A design that tied the timestamp state to the MAC reset, or skipped the counter, would show different words or timestamps. A long random phase with frequent threshold rewrites is compared with a behavioural model on every clock.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    // Global register: soft reset control position
    localparam int SRST_BIT = 11;
    // Offsets inside a port block (address bits [3:0])
    localparam logic [3:0] OFS_CFG  = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    // Config word field positions (threshold occupies the low bits)
    localparam int CFG_EN_BIT = 4;
    // Status word field positions (valid bitmap occupies the low bits)
    localparam int STAT_OVF_BIT   = 8;
    localparam int STAT_CNT_LSB   = 16;
    localparam int STAT_CAUSE_BIT = 24;
endpackage

// File: rtl/tsq_port_slice.sv
module tsq_port_slice #(
    parameter  int SLOTS = 4,
    parameter  int TS_W  = 16,
    parameter  int THR_W = 3,
    localparam int CW    = $clog2(SLOTS + 1),
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        soft_rst,
    input  logic [TS_W-1:0]             time_now,
    input  logic                        cap,
    input  logic                        rd_en,
    input  logic [SW-1:0]               rd_idx,
    input  logic [THR_W-1:0]            cfg_thr,
    input  logic                        cfg_en,
    output logic [SLOTS-1:0]            valid_o,
    output logic [CW-1:0]               cnt_o,
    output logic                        ovf_o,
    output logic                        cause_o,
    output logic [TS_W-1:0]             rd_ts_o
);
    typedef struct packed {
        logic [SLOTS-1:0]            valid;
        logic [SLOTS-1:0][TS_W-1:0]  mem;
        logic [CW-1:0]               cnt;
        logic [THR_W-1:0]            athr;   // threshold in force when cause rose
        logic                        ovf;
        logic                        cause;
    } slice_t;

    slice_t        s_d, s_q;
    logic          rd_hit;
    logic          free_ok;
    logic [SW-1:0] free_idx;

    always_comb begin
        s_d      = s_q;
        rd_hit   = rd_en && s_q.valid[rd_idx];
        free_ok  = 1'b0;
        free_idx = '0;
        // descending scan leaves the lowest free slot selected
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!s_q.valid[i]) begin
                free_ok  = 1'b1;
                free_idx = SW'(i);
            end
        end
        if (rd_hit) begin
            s_d.valid[rd_idx] = 1'b0;
        end
        if (cap) begin
            if (free_ok) begin
                s_d.valid[free_idx] = 1'b1;
                s_d.mem[free_idx]   = time_now;
            end else begin
                s_d.ovf = 1'b1;
            end
        end
        s_d.cnt = s_q.cnt + CW'(cap && free_ok) - CW'(rd_hit);
        // clear is judged only when the count actually falls
        if ((s_d.cnt < s_q.cnt) && (int'(s_d.cnt) < int'(s_q.athr))) begin
            s_d.cause = 1'b0;
        end else if (cfg_en && (int'(s_q.cnt) >= int'(cfg_thr))) begin
            if (!s_q.cause) begin
                s_d.athr = cfg_thr;
            end
            s_d.cause = 1'b1;
        end
        if (soft_rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = s_q.valid;
    assign cnt_o   = s_q.cnt;
    assign ovf_o   = s_q.ovf;
    assign cause_o = s_q.cause;
    assign rd_ts_o = s_q.valid[rd_idx] ? s_q.mem[rd_idx] : '0;
endmodule

// File: rtl/tsq_regbank.sv
module tsq_regbank
    import tsq_pkg::*;
#(
    parameter  int NP    = 4,
    parameter  int SLOTS = 4,
    parameter  int TS_W  = 16,
    parameter  int THR_W = 3,
    localparam int CW    = $clog2(SLOTS + 1),
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         mac_rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [7:0]                   bus_addr,
    input  logic [31:0]                  bus_wdata,
    input  logic [NP-1:0][SLOTS-1:0]     valid_i,
    input  logic [NP-1:0][CW-1:0]        cnt_i,
    input  logic [NP-1:0]                ovf_i,
    input  logic [NP-1:0]                cause_i,
    input  logic [NP-1:0][TS_W-1:0]      ts_i,
    output logic                         soft_rst_o,
    output logic [NP-1:0][THR_W-1:0]     cfg_thr_o,
    output logic [NP-1:0]                cfg_en_o,
    output logic [NP-1:0]                slot_rd_o,
    output logic [SW-1:0]                slot_idx_o,
    output logic [31:0]                  bus_rdata
);
    typedef struct packed {
        logic                     sr;
        logic [NP-1:0][THR_W-1:0] thr;
        logic [NP-1:0]            en;
    } regs_t;

    regs_t       r_d, r_q;
    logic [31:0] rdata_d, rdata_q;
    logic [31:0] rv;
    logic [NP-1:0] port_sel;
    logic [3:0]  ofs;
    logic        slot_ok;
    logic        unused_wbits;

    assign ofs     = bus_addr[3:0];
    assign slot_ok = ofs[3] && (int'(ofs[2:0]) < SLOTS);
    assign unused_wbits = ^{bus_wdata[31:SRST_BIT+1], bus_wdata[SRST_BIT-1:CFG_EN_BIT+1],
                            bus_wdata[CFG_EN_BIT-1:THR_W]};

    for (genvar p = 0; p < NP; p++) begin : g_sel
        assign port_sel[p]  = (bus_addr[7:4] == 4'(p + 1));
        assign slot_rd_o[p] = bus_rd && port_sel[p] && slot_ok;
    end

    always_comb begin
        r_d = r_q;
        rv  = '0;
        if (bus_wr && (bus_addr == 8'h00)) begin
            r_d.sr = bus_wdata[SRST_BIT];
        end
        if (bus_addr == 8'h00) begin
            rv[SRST_BIT] = r_q.sr;
        end
        for (int p = 0; p < NP; p++) begin
            if (bus_wr && port_sel[p] && (ofs == OFS_CFG)) begin
                r_d.thr[p] = bus_wdata[THR_W-1:0];
                r_d.en[p]  = bus_wdata[CFG_EN_BIT];
            end
            if (port_sel[p]) begin
                if (ofs == OFS_CFG) begin
                    rv[THR_W-1:0]  = r_q.thr[p];
                    rv[CFG_EN_BIT] = r_q.en[p];
                end else if (ofs == OFS_STAT) begin
                    rv[SLOTS-1:0]           = valid_i[p];
                    rv[STAT_OVF_BIT]        = ovf_i[p];
                    rv[STAT_CNT_LSB +: CW]  = cnt_i[p];
                    rv[STAT_CAUSE_BIT]      = cause_i[p];
                end else if (slot_ok) begin
                    rv[TS_W-1:0] = ts_i[p];
                end
            end
        end
        rdata_d = bus_rd ? rv : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // read-data register sits on the MAC side and follows its reset
    always_ff @(posedge clk) begin
        if (!por_n || !mac_rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign soft_rst_o = r_q.sr;
    assign cfg_thr_o  = r_q.thr;
    assign cfg_en_o   = r_q.en;
    assign slot_idx_o = ofs[SW-1:0];
    assign bus_rdata  = rdata_q;
endmodule

// File: rtl/tsq_irq_unit.sv
module tsq_irq_unit #(
    parameter  int NUM_PORTS = 4,
    parameter  int SLOTS     = 4,
    parameter  int TS_W      = 16,
    parameter  int THR_W     = 3,
    localparam int CW        = $clog2(SLOTS + 1),
    localparam int SW        = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  por_rst_n,
    input  logic                  mac_rst_n,
    input  logic [NUM_PORTS-1:0]  cap_strobe,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  quad_irq
);
    logic                                soft_rst;
    logic [NUM_PORTS-1:0][THR_W-1:0]     cfg_thr;
    logic [NUM_PORTS-1:0]                cfg_en;
    logic [NUM_PORTS-1:0]                slot_rd;
    logic [SW-1:0]                       slot_idx;
    logic [NUM_PORTS-1:0][SLOTS-1:0]     valid;
    logic [NUM_PORTS-1:0][CW-1:0]        cnt;
    logic [NUM_PORTS-1:0]                ovf;
    logic [NUM_PORTS-1:0]                cause;
    logic [NUM_PORTS-1:0][TS_W-1:0]      rd_ts;
    logic [TS_W-1:0]                     timer_d, timer_q;

    always_comb begin
        timer_d = soft_rst ? '0 : timer_q + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!por_rst_n) begin
            timer_q <= '0;
        end else begin
            timer_q <= timer_d;
        end
    end

    tsq_regbank #(
        .NP(NUM_PORTS), .SLOTS(SLOTS), .TS_W(TS_W), .THR_W(THR_W)
    ) u_regs (
        .clk(clk), .por_n(por_rst_n), .mac_rst_n(mac_rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .valid_i(valid), .cnt_i(cnt), .ovf_i(ovf), .cause_i(cause), .ts_i(rd_ts),
        .soft_rst_o(soft_rst), .cfg_thr_o(cfg_thr), .cfg_en_o(cfg_en),
        .slot_rd_o(slot_rd), .slot_idx_o(slot_idx), .bus_rdata(bus_rdata)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tsq_port_slice #(
            .SLOTS(SLOTS), .TS_W(TS_W), .THR_W(THR_W)
        ) u_slice (
            .clk(clk), .por_n(por_rst_n), .soft_rst(soft_rst), .time_now(timer_q),
            .cap(cap_strobe[p]), .rd_en(slot_rd[p]), .rd_idx(slot_idx),
            .cfg_thr(cfg_thr[p]), .cfg_en(cfg_en[p]),
            .valid_o(valid[p]), .cnt_o(cnt[p]), .ovf_o(ovf[p]),
            .cause_o(cause[p]), .rd_ts_o(rd_ts[p])
        );
    end

    assign quad_irq = |cause;
endmodule

// File: rtl/tsq_irq_checker.sv
module tsq_irq_checker #(
    parameter  int NP    = 4,
    parameter  int SLOTS = 4,
    parameter  int THR_W = 3,
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     por_rst_n,
    input  logic                     mac_rst_n,
    input  logic                     bus_rd,
    input  logic                     quad_irq,
    input  logic [31:0]              bus_rdata,
    input  logic                     soft_rst,
    input  logic [NP-1:0][SLOTS-1:0] valid,
    input  logic [NP-1:0][CW-1:0]    cnt,
    input  logic [NP-1:0]            cause,
    input  logic [NP-1:0][THR_W-1:0] cfg_thr,
    input  logic [NP-1:0]            cfg_en
);
    for (genvar p = 0; p < NP; p++) begin : g_chk
        assert_cnt_track_R2: assert property (@(posedge clk) disable iff (!por_rst_n)
            int'(cnt[p]) == $countones(valid[p]))
            else $error("count does not follow valid bitmap on port %0d", p);

        assert_raise_R5: assert property (@(posedge clk) disable iff (!por_rst_n)
            (cfg_en[p] && (int'(cnt[p]) >= int'(cfg_thr[p])) && !soft_rst && !bus_rd) |=> cause[p])
            else $error("cause not raised at threshold on port %0d", p);

        assert_zero_stuck_R6: assert property (@(posedge clk) disable iff (!por_rst_n)
            (cause[p] && (cfg_thr[p] == '0) && !soft_rst) |=> cause[p])
            else $error("zero-threshold cause dropped on port %0d", p);
    end

    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!por_rst_n)
        $fell(quad_irq) |-> $past(bus_rd || soft_rst))
        else $error("quad interrupt fell without a read or soft reset");

    assert_srst_clear_R8: assert property (@(posedge clk) disable iff (!por_rst_n)
        soft_rst |=> ((valid == '0) && !quad_irq))
        else $error("soft reset did not clear timestamp state");

    assert_mac_rdata_R9: assert property (@(posedge clk) disable iff (!por_rst_n)
        !mac_rst_n |=> (bus_rdata == 32'h0))
        else $error("MAC reset did not clear read data");
endmodule

bind tsq_irq_unit tsq_irq_checker #(
    .NP(NUM_PORTS), .SLOTS(SLOTS), .THR_W(THR_W)
) u_chk (
    .clk(clk), .por_rst_n(por_rst_n), .mac_rst_n(mac_rst_n), .bus_rd(bus_rd),
    .quad_irq(quad_irq), .bus_rdata(bus_rdata), .soft_rst(soft_rst),
    .valid(valid), .cnt(cnt), .cause(cause), .cfg_thr(cfg_thr), .cfg_en(cfg_en)
);

// File: tb/tsq_irq_unit_bench.sv
module tsq_irq_unit_bench;
    localparam int NP = 4;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        por_rst_n = 1'b0;
    logic        mac_rst_n = 1'b1;
    logic [3:0]  cap_strobe = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        quad_irq;

    int total = 0;
    int bad = 0;
    bit lock_en = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int   m_cnt[NP];
    bit   m_val[NP][NS];
    int   m_ts[NP][NS];
    bit   m_ovf[NP];
    bit   m_cause[NP];
    int   m_athr[NP];
    int   m_thr[NP];
    bit   m_en[NP];
    bit   m_sr;
    int   m_timer;
    logic [31:0] m_rdata;

    always #5 clk = ~clk;

    tsq_irq_unit u_tsq_irq_unit (
        .clk(clk), .por_rst_n(por_rst_n), .mac_rst_n(mac_rst_n), .cap_strobe(cap_strobe),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .quad_irq(quad_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] v;
        int p;
        v = '0;
        p = int'(a[7:4]) - 1;
        if (a == 8'h00) begin
            v[11] = m_sr;
        end else if (p >= 0 && p < NP) begin
            if (a[3:0] == 4'h0) begin
                v[2:0] = 3'(m_thr[p]);
                v[4]   = m_en[p];
            end else if (a[3:0] == 4'h4) begin
                for (int s = 0; s < NS; s++) v[s] = m_val[p][s];
                v[8]     = m_ovf[p];
                v[18:16] = 3'(m_cnt[p]);
                v[24]    = m_cause[p];
            end else if (a[3] && !a[2]) begin
                if (m_val[p][a[1:0]]) v[15:0] = 16'(m_ts[p][a[1:0]]);
            end
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!por_rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_cnt[p] = 0; m_ovf[p] = 0; m_cause[p] = 0; m_athr[p] = 0;
                m_thr[p] = 0; m_en[p] = 0;
                for (int s = 0; s < NS; s++) begin m_val[p][s] = 0; m_ts[p][s] = 0; end
            end
            m_sr = 0; m_timer = 0; m_rdata = '0;
        end else begin
            logic [31:0] rv;
            rv = model_read(bus_addr);
            if (!mac_rst_n) m_rdata = '0;
            else if (bus_rd) m_rdata = rv;
            if (m_sr) begin
                for (int p = 0; p < NP; p++) begin
                    m_cnt[p] = 0; m_ovf[p] = 0; m_cause[p] = 0; m_athr[p] = 0;
                    for (int s = 0; s < NS; s++) begin m_val[p][s] = 0; m_ts[p][s] = 0; end
                end
                m_timer = 0;
            end else begin
                for (int p = 0; p < NP; p++) begin
                    int free_s, old, got, hit;
                    free_s = -1;
                    for (int s = NS - 1; s >= 0; s--) if (!m_val[p][s]) free_s = s;
                    hit = (bus_rd && int'(bus_addr[7:4]) == p + 1 && bus_addr[3] && !bus_addr[2]
                           && m_val[p][bus_addr[1:0]]) ? 1 : 0;
                    if (hit == 1) m_val[p][bus_addr[1:0]] = 0;
                    got = 0;
                    if (cap_strobe[p]) begin
                        if (free_s >= 0) begin
                            m_val[p][free_s] = 1; m_ts[p][free_s] = m_timer; got = 1;
                        end else m_ovf[p] = 1;
                    end
                    old = m_cnt[p];
                    m_cnt[p] = old + got - hit;
                    if (m_cnt[p] < old && m_cnt[p] < m_athr[p]) m_cause[p] = 0;
                    else if (m_en[p] && old >= m_thr[p]) begin
                        if (!m_cause[p]) m_athr[p] = m_thr[p];
                        m_cause[p] = 1;
                    end
                end
                m_timer = (m_timer + 1) & 16'hFFFF;
            end
            if (bus_wr) begin
                if (bus_addr == 8'h00) m_sr = bus_wdata[11];
                else if (bus_addr[3:0] == 4'h0 && bus_addr[7:4] >= 4'd1 && bus_addr[7:4] <= 4'd4) begin
                    m_thr[int'(bus_addr[7:4]) - 1] = int'(bus_wdata[2:0]);
                    m_en[int'(bus_addr[7:4]) - 1]  = bus_wdata[4];
                end
            end
        end
    end

    // lockstep comparison every clock, away from the active edge
    always @(negedge clk) begin
        if (lock_en && !done) begin
            logic e_irq;
            e_irq = 1'b0;
            for (int p = 0; p < NP; p++) e_irq = e_irq | m_cause[p];
            chk("R7 lockstep quad_irq", {31'b0, quad_irq}, {31'b0, e_irq});
            chk("R4 lockstep bus_rdata", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic cap(input logic [3:0] m);
        cap_strobe = m;
        @(negedge clk);
        cap_strobe = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        por_rst_n = 1'b1;
        lock_en = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 quad_irq after reset", {31'b0, quad_irq}, 32'h0);
        chk("R1 bus_rdata after reset", bus_rdata, 32'h0);
        rd_chk(8'h10, 32'h0, "R1 port0 config reset");
        rd_chk(8'h14, 32'h0, "R1 port0 status reset");
        rd_chk(8'h00, 32'h0, "R1 global reset");

        // R2 capture into lowest free slots, interrupt disabled
        cap(4'b0001);
        cap(4'b0001);
        rd_chk(8'h14, 32'h0002_0003, "R2 port0 two captures");
        chk("R5 disabled port stays quiet", {31'b0, quad_irq}, 32'h0);

        // threshold written first, enable in a later write
        wr(8'h10, 32'h1);
        wr(8'h10, 32'h11);
        idle(1);
        chk("R5 raise at count>=threshold", {31'b0, quad_irq}, 32'h1);
        rd_chk(8'h18, 32'(m_ts[0][0]), "R4 slot0 timestamp");
        chk("R6 stays high at count==threshold", {31'b0, quad_irq}, 32'h1);
        rd_chk(8'h19, 32'(m_ts[0][1]), "R4 slot1 timestamp");
        chk("R6 clears below threshold", {31'b0, quad_irq}, 32'h0);
        rd_chk(8'h19, 32'h0, "R4 empty slot reads zero");
        rd_chk(8'h14, 32'h0, "R4 port0 drained");
        cap(4'b0001);
        idle(1);
        chk("R5 threshold one single capture", {31'b0, quad_irq}, 32'h1);
        rd_chk(8'h18, 32'(m_ts[0][0]), "R4 slot0 reuse");
        chk("R6 threshold one clears", {31'b0, quad_irq}, 32'h0);

        // R3 overflow on port1
        for (int i = 0; i < 5; i++) cap(4'b0010);
        rd_chk(8'h24, 32'h0004_010F, "R3 full port overflow");
        rd_chk(8'h2A, 32'(m_ts[1][2]), "R4 port1 slot2");
        cap(4'b0010);
        rd_chk(8'h24, 32'h0004_010F, "R3 overflow sticky after refill");

        // R6 stuck with zero threshold on port2 (single write)
        wr(8'h30, 32'h10);
        idle(1);
        chk("R6 zero threshold raises", {31'b0, quad_irq}, 32'h1);
        rd_chk(8'h34, 32'h0100_0000, "R6 port2 cause bit");
        wr(8'h30, 32'h13);
        idle(3);
        chk("R6 new threshold does not clear", {31'b0, quad_irq}, 32'h1);
        cap(4'b0100);
        rd_chk(8'h38, 32'(m_ts[2][0]), "R4 port2 slot0");
        rd_chk(8'h34, 32'h0100_0000, "R6 drain does not clear stuck cause");

        // R7 other port hidden behind the stuck one
        cap(4'b0001);
        idle(1);
        rd_chk(8'h14, 32'h0101_0001, "R7 port0 cause set");
        rd_chk(8'h18, 32'(m_ts[0][0]), "R4 port0 read under mask");
        rd_chk(8'h14, 32'h0, "R7 port0 cause cleared");
        chk("R7 quad irq still held by port2", {31'b0, quad_irq}, 32'h1);

        // R9 MAC reset leaves timestamp state alone
        rd_chk(8'h24, 32'h0004_010F, "R9 status before MAC reset");
        mac_rst_n = 1'b0;
        idle(3);
        chk("R9 read data cleared by MAC reset", bus_rdata, 32'h0);
        chk("R9 irq unchanged by MAC reset", {31'b0, quad_irq}, 32'h1);
        mac_rst_n = 1'b1;
        rd_chk(8'h24, 32'h0004_010F, "R9 port1 status kept");
        rd_chk(8'h34, 32'h0100_0000, "R9 port2 status kept");
        rd_chk(8'h30, 32'h13, "R9 port2 config kept");

        // R8 recovery: disable, then clear-set-clear soft reset
        wr(8'h30, 32'h01);
        chk("R6 clearing enable does not clear", {31'b0, quad_irq}, 32'h1);
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h800);
        wr(8'h00, 32'h0);
        cap(4'b0100);
        chk("R8 soft reset clears irq", {31'b0, quad_irq}, 32'h0);
        rd_chk(8'h38, 32'h0, "R10 first capture after soft reset is time 0");
        idle(2);
        cap(4'b0100);
        rd_chk(8'h38, 32'h4, "R10 counter advances each cycle");
        rd_chk(8'h24, 32'h0, "R8 port1 cleared incl overflow");
        rd_chk(8'h34, 32'h0, "R8 port2 cleared");
        rd_chk(8'h30, 32'h01, "R8 port2 config kept");
        rd_chk(8'h10, 32'h11, "R8 port0 config kept");
        rd_chk(8'h00, 32'h0, "R8 soft reset bit reads back clear");
        wr(8'h30, 32'h11);
        idle(2);
        chk("R5 safe enable no spurious irq", {31'b0, quad_irq}, 32'h0);
        cap(4'b0100);
        idle(1);
        chk("R5 port2 recovered raises", {31'b0, quad_irq}, 32'h1);
        rd_chk(8'h38, 32'(m_ts[2][0]), "R4 port2 recovered read");
        chk("R6 port2 recovered clears", {31'b0, quad_irq}, 32'h0);

        // random traffic against the model
        for (int p = 0; p < NP; p++) wr(8'(16 * (p + 1)), 32'h10 | 32'(1 + p));
        for (int i = 0; i < 4000; i++) begin
            cap_strobe = 4'($urandom);
            bus_rd     = ($urandom % 3) != 0;
            bus_addr   = {4'(1 + $urandom % 4), ($urandom % 5 == 0) ? 4'h4 : 4'(8 + $urandom % 4)};
            if ($urandom % 40 == 0) begin
                bus_rd    = 1'b0;
                bus_wr    = 1'b1;
                bus_addr  = {4'(1 + $urandom % 4), 4'h0};
                bus_wdata = 32'h10 | 32'(1 + $urandom % 7);
            end
            @(negedge clk);
            bus_wr = 1'b0;
        end
        cap_strobe = '0;
        bus_rd = 1'b0;
        idle(2);
        finish_run();
    end
endmodule